// File: doc/BRIEF.md
# Byte-Stream JTAG and Serial-Configuration Command Engine

This block turns a stream of host bytes into pin activity on a JTAG chain or on a serial FPGA-configuration target, and sends results back to the host. Bytes arrive on a valid/ready receive stream, and response bytes leave on a valid/ready transmit stream. Both streams are normally fed by a USB FIFO bridge. JTAG and serial configuration use the same six outputs and two inputs. In JTAG use the pins carry TCK, TMS and TDI and return TDO. In configuration use they carry DCLK, nCONFIG, nCE, nCS and ASDI/DATA0, and they return CONF_DONE and DATAOUT/nSTATUS.

Each command byte selects one of two modes.

- **Bit-bang mode** (bit 7 clear) loads all six outputs at once from bits 5:0 of the command. If bit 6 is set, the two inputs are returned as one response byte.
- **Byte-shift mode** (bit 7 set) takes bits 5:0 as a count of data bytes. Each data byte is clocked out on TDI, least significant bit first, with one TCK pulse per bit. The bits arriving on the selected input are assembled into a byte. If bit 6 is set, that byte is returned to the host.

The host issues one of the two modes at a time.

The block has no reset input. Its 4-bit sequencer gives a defined successor to every code, and a zero byte moves it toward the command state. A host that opens every session with 64 zero bytes therefore always finds the engine waiting for a command.

Top module: `usbjtag_engine`

## Requirements
- R1: A bit-bang command (bit 7 = 0) drives its bits 5:0 onto the outputs in one step, in this mapping:
  - bit 0 → TCK
  - bit 1 → TMS
  - bit 2 → nCE
  - bit 3 → nCS
  - bit 4 → TDI
  - bit 5 → driver enable

  The outputs change on the second clock edge after the byte is accepted. The driver-enable output must be 1 for the external pad drivers to drive the target; when it is 0 they are high-impedance.
- R2: A bit-bang command with bit 6 = 1 returns exactly one byte. Bit 0 of that byte is TDO and bit 1 is ASDO, both sampled on the edge that loads the outputs. Bits 7:2 are zero.
- R3: A bit-bang command with bit 6 = 0 produces no response byte.
- R4: A byte-shift command (bit 7 = 1) consumes exactly bits 5:0 further bytes as shift data. A count of zero consumes none, and the next byte is decoded as a command.
- R5: Every data bit takes two steps:
  - TDI takes the next bit, least significant first, and TCK is driven low.
  - TCK is driven high.

  Each data byte therefore gives exactly 8 rising TCK edges.
- R6: On each rising TCK step the engine captures one bit. It takes TDO when nCS is 1 and ASDO when nCS is 0.
- R7: With bit 6 = 1, one captured byte is returned after each data byte, with the first captured bit in bit 0. With bit 6 = 0, no byte is returned.
- R8: While the receive stream has no byte or the transmit stream is not ready, the engine waits. During the wait TCK and TDI hold their levels and a pending response byte stays unchanged. No data is lost.
- R9: During byte shifting only TCK and TDI change. TMS, nCE, nCS and driver enable keep their last bit-bang values. TCK is low once a transfer ends.
- R10: The outputs settle to all zero and no response is pending after 64 consecutive zero bytes are accepted while the transmit stream is ready, starting from any state. This includes the middle of a transfer. The next command then executes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rx_data | input | 8 | Host byte (command or shift data) |
| rx_valid | input | 1 | Host byte present |
| rx_ready | output | 1 | Engine accepts a host byte this cycle |
| tx_data | output | 8 | Response byte |
| tx_valid | output | 1 | Response byte present |
| tx_ready | input | 1 | Host accepts the response byte |
| tdo_i | input | 1 | TDO / CONF_DONE from target |
| asdo_i | input | 1 | ASDO/DATAOUT / nSTATUS from target |
| tck_o | output | 1 | TCK / DCLK |
| tms_o | output | 1 | TMS / nCONFIG |
| nce_o | output | 1 | nCE |
| ncs_o | output | 1 | nCS; also selects the capture source |
| tdi_o | output | 1 | TDI / ASDI / DATA0 |
| drv_en_o | output | 1 | LED and target pad-driver enable |

## Verification
The following are checked on every cycle once the sequencer has first reached its command state:
- TCK is low at the start of every high step.
- A waiting response holds its byte.
- TCK and TDI hold during a receive wait.
- TMS, nCE, nCS and driver enable stay frozen through byte shifting.
- The upper six read-back bits are zero.
- Each shifted-in bit comes from the input that nCS selects.

The bench scenarios cover the end-to-end results that only a complete transaction can show:
- the order of TDI bits as a target sees them
- the captured byte values
- the exact number of bytes a count consumes
- the absence of responses
- the 64-zero recovery from the middle of a long transfer

// File: rtl/usbjtag_pkg.sv
package usbjtag_pkg;

    localparam int BYTE_W       = 8;
    localparam int CNT_W        = 6;
    localparam int PIN_N        = 6;
    localparam int BITC_W       = $clog2(BYTE_W) + 1;
    localparam int OP_SHIFT_BIT = 7;
    localparam int OP_READ_BIT  = 6;

    // Sixteen codes, each with a defined successor.
    typedef enum logic [3:0] {
        ST_IDLE     = 4'd0,
        ST_BB_SET   = 4'd1,
        ST_BB_RESP  = 4'd2,
        ST_BS_FETCH = 4'd3,
        ST_BS_LOW   = 4'd4,
        ST_BS_HIGH  = 4'd5,
        ST_BS_RESP  = 4'd6,
        ST_BS_NEXT  = 4'd7,
        ST_SPARE8   = 4'd8,
        ST_SPARE9   = 4'd9,
        ST_SPARE10  = 4'd10,
        ST_SPARE11  = 4'd11,
        ST_SPARE12  = 4'd12,
        ST_SPARE13  = 4'd13,
        ST_SPARE14  = 4'd14,
        ST_SPARE15  = 4'd15
    } seq_state_e;

    // Packed so that the least significant member matches command bit 0.
    typedef struct packed {
        logic oe;
        logic tdi;
        logic ncs;
        logic nce;
        logic tms;
        logic tck;
    } pin_bus_t;

    typedef struct packed {
        logic             shift;
        logic             read;
        logic [CNT_W-1:0] arg;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [BYTE_W-1:0] b);
        cmd_t c;
        c.shift = b[OP_SHIFT_BIT];
        c.read  = b[OP_READ_BIT];
        c.arg   = b[CNT_W-1:0];
        return c;
    endfunction

    function automatic logic is_shift_state(input seq_state_e s);
        return (s == ST_BS_FETCH) || (s == ST_BS_LOW) || (s == ST_BS_HIGH) ||
               (s == ST_BS_RESP)  || (s == ST_BS_NEXT);
    endfunction

endpackage

// File: rtl/usbjtag_seq.sv
module usbjtag_seq
    import usbjtag_pkg::*;
#(
    parameter int DW  = BYTE_W,
    parameter int CW  = CNT_W,
    localparam int BCW = $clog2(DW) + 1
) (
    input  logic          clk,
    input  logic [DW-1:0] rx_data,
    input  logic          rx_valid,
    output logic          rx_ready,
    input  logic          tx_ready,
    output logic          tx_valid,
    output seq_state_e    state_o,
    output logic          armed_o,
    output logic          take_byte,
    output logic          bb_set,
    output logic          bit_low,
    output logic          bit_high,
    output logic          xfer_end
);

    seq_state_e     state;
    logic [CW-1:0]  bytecnt;
    logic [BCW-1:0] bitcnt;
    logic           want_rd;
    logic           armed;
    cmd_t           cmd;

    assign cmd       = decode_cmd(rx_data);
    assign rx_ready  = (state == ST_IDLE) || (state == ST_BS_FETCH);
    assign tx_valid  = (state == ST_BB_RESP) || (state == ST_BS_RESP);
    assign take_byte = rx_ready && rx_valid && ((state == ST_BS_FETCH) || !cmd.shift);
    assign bb_set    = (state == ST_BB_SET);
    assign bit_low   = (state == ST_BS_LOW);
    assign bit_high  = (state == ST_BS_HIGH);
    assign xfer_end  = (state == ST_BS_NEXT) && (bytecnt <= CW'(1));
    assign state_o   = state;
    assign armed_o   = armed;

    always_ff @(posedge clk) begin
        armed <= armed | (state == ST_IDLE);
        case (state)
            ST_IDLE: begin
                if (rx_valid) begin
                    want_rd <= cmd.read;
                    if (cmd.shift) begin
                        bytecnt <= cmd.arg;
                        state   <= (cmd.arg == '0) ? ST_IDLE : ST_BS_FETCH;
                    end else begin
                        state <= ST_BB_SET;
                    end
                end
            end
            ST_BB_SET:  state <= want_rd ? ST_BB_RESP : ST_IDLE;
            ST_BB_RESP: if (tx_ready) state <= ST_IDLE;
            ST_BS_FETCH: begin
                if (rx_valid) begin
                    bitcnt <= BCW'(DW);
                    state  <= ST_BS_LOW;
                end
            end
            ST_BS_LOW: begin
                bitcnt <= bitcnt - BCW'(1);
                state  <= ST_BS_HIGH;
            end
            ST_BS_HIGH: begin
                if (bitcnt == '0) state <= want_rd ? ST_BS_RESP : ST_BS_NEXT;
                else              state <= ST_BS_LOW;
            end
            ST_BS_RESP: if (tx_ready) state <= ST_BS_NEXT;
            ST_BS_NEXT: begin
                bytecnt <= bytecnt - CW'(1);
                state   <= (bytecnt <= CW'(1)) ? ST_IDLE : ST_BS_FETCH;
            end
            default: state <= ST_IDLE;
        endcase
    end

    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!armed)
        (state == ST_IDLE && rx_valid && cmd.shift && cmd.arg == '0) |=> (state == ST_IDLE)); // R4

    AST_RESP_HOLD: assert property (@(posedge clk) disable iff (!armed)
        (tx_valid && !tx_ready) |=> tx_valid); // R8

endmodule

// File: rtl/usbjtag_shift.sv
module usbjtag_shift #(
    parameter int DW = usbjtag_pkg::BYTE_W
) (
    input  logic          clk,
    input  logic          armed,
    input  logic          load,
    input  logic [DW-1:0] load_val,
    input  logic          bb_cap,
    input  logic          step,
    input  logic          tdo,
    input  logic          asdo,
    input  logic          ncs,
    output logic [DW-1:0] sh
);

    logic carry;

    // nCS high means JTAG use (TDO); low means serial-flash use (ASDO).
    assign carry = ncs ? tdo : asdo;

    always_ff @(posedge clk) begin
        if (load)
            sh <= load_val;
        else if (bb_cap)
            sh <= {{(DW-2){1'b0}}, asdo, tdo};
        else if (step)
            sh <= {carry, sh[DW-1:1]};
    end

    AST_CAPTURE_SOURCE: assert property (@(posedge clk) disable iff (!armed)
        (step && !load && !bb_cap) |=> (sh[DW-1] == $past(ncs ? tdo : asdo))); // R6

endmodule

// File: rtl/usbjtag_pins.sv
module usbjtag_pins
    import usbjtag_pkg::*;
(
    input  logic     clk,
    input  logic     armed,
    input  logic     bb_load,
    input  pin_bus_t bb_val,
    input  logic     tdi_set,
    input  logic     tdi_val,
    input  logic     tck_rise,
    input  logic     tck_fall,
    output pin_bus_t pins
);

    always_ff @(posedge clk) begin
        if (bb_load) begin
            pins <= bb_val;
        end else begin
            if (tdi_set)       pins.tdi <= tdi_val;
            if (tck_fall)      pins.tck <= 1'b0;
            else if (tck_rise) pins.tck <= 1'b1;
        end
    end

    AST_BB_LOAD: assert property (@(posedge clk) disable iff (!armed)
        bb_load |=> (pins == $past(bb_val))); // R1

endmodule

// File: rtl/usbjtag_engine.sv
module usbjtag_engine
    import usbjtag_pkg::*;
(
    input  logic              clk,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_valid,
    output logic              rx_ready,
    output logic [BYTE_W-1:0] tx_data,
    output logic              tx_valid,
    input  logic              tx_ready,
    input  logic              tdo_i,
    input  logic              asdo_i,
    output logic              tck_o,
    output logic              tms_o,
    output logic              nce_o,
    output logic              ncs_o,
    output logic              tdi_o,
    output logic              drv_en_o
);

    seq_state_e        st;
    logic              armed;
    logic              take_byte, bb_set, bit_low, bit_high, xfer_end;
    logic [BYTE_W-1:0] sh;
    pin_bus_t          pins;

    usbjtag_seq #(.DW(BYTE_W), .CW(CNT_W)) u_seq (
        .clk       (clk),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .rx_ready  (rx_ready),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .state_o   (st),
        .armed_o   (armed),
        .take_byte (take_byte),
        .bb_set    (bb_set),
        .bit_low   (bit_low),
        .bit_high  (bit_high),
        .xfer_end  (xfer_end)
    );

    usbjtag_shift #(.DW(BYTE_W)) u_shift (
        .clk      (clk),
        .armed    (armed),
        .load     (take_byte),
        .load_val (rx_data),
        .bb_cap   (bb_set),
        .step     (bit_high),
        .tdo      (tdo_i),
        .asdo     (asdo_i),
        .ncs      (pins.ncs),
        .sh       (sh)
    );

    usbjtag_pins u_pins (
        .clk      (clk),
        .armed    (armed),
        .bb_load  (bb_set),
        .bb_val   (pin_bus_t'(sh[PIN_N-1:0])),
        .tdi_set  (bit_low),
        .tdi_val  (sh[0]),
        .tck_rise (bit_high),
        .tck_fall (bit_low | xfer_end),
        .pins     (pins)
    );

    assign tx_data  = sh;
    assign tck_o    = pins.tck;
    assign tms_o    = pins.tms;
    assign nce_o    = pins.nce;
    assign ncs_o    = pins.ncs;
    assign tdi_o    = pins.tdi;
    assign drv_en_o = pins.oe;

    AST_TX_STABLE: assert property (@(posedge clk) disable iff (!armed)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R8

    AST_FETCH_STALL: assert property (@(posedge clk) disable iff (!armed)
        (st == ST_BS_FETCH && !rx_valid) |=> ($stable(tck_o) && $stable(tdi_o))); // R8

    AST_TCK_PHASE: assert property (@(posedge clk) disable iff (!armed)
        (st == ST_BS_HIGH) |-> !tck_o); // R5

    AST_PINS_FROZEN: assert property (@(posedge clk) disable iff (!armed)
        is_shift_state(st) |=> $stable({tms_o, nce_o, ncs_o, drv_en_o})); // R9

    AST_READBACK_UPPER: assert property (@(posedge clk) disable iff (!armed)
        (st == ST_BB_RESP) |-> (tx_data[BYTE_W-1:2] == '0)); // R2

endmodule

// File: tb/sim_usbjtag_engine.sv
module sim_usbjtag_engine;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_valid = 1'b0;
    logic       rx_ready;
    logic [7:0] tx_data;
    logic       tx_valid;
    logic       tx_ready = 1'b0;
    logic       tdo_i, asdo_i;
    logic       tck_o, tms_o, nce_o, ncs_o, tdi_o, drv_en_o;

    int vectors = 0;
    int fails   = 0;

    // Target model.
    bit   bb_mode = 1'b1;
    logic tdo_f   = 1'b0;
    logic asdo_f  = 1'b0;
    int   seed    = 0;
    int   bitidx  = 0;
    logic tdi_log [0:511];

    // Monitor flags.
    bit       mon_on  = 1'b0;
    bit       glitch  = 1'b0;
    bit       txseen  = 1'b0;
    logic [3:0] mon_exp = 4'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic patbit(input int i, input int s);
        int h;
        h = i * 29 + s * 13 + (i >> 2) * 7;
        return logic'((h ^ (h >> 3)) & 1);
    endfunction

    function automatic logic [7:0] dbyte(input int k, input int s);
        return 8'((k * 37 + s * 11 + 5) ^ (k << 3));
    endfunction

    assign tdo_i  = bb_mode ? tdo_f  : patbit(bitidx, seed);
    assign asdo_i = bb_mode ? asdo_f : patbit(bitidx, seed + 3);

    always @(posedge tck_o) begin
        if (bitidx < 512) tdi_log[bitidx] = tdi_o;
        bitidx = bitidx + 1;
    end

    always @(negedge clk) begin
        if (mon_on) begin
            if ({drv_en_o, ncs_o, nce_o, tms_o} !== mon_exp) glitch = 1'b1;
            if (tx_valid) txseen = 1'b1;
        end
    end

    usbjtag_engine u0 (
        .clk      (clk),
        .rx_data  (rx_data),
        .rx_valid (rx_valid),
        .rx_ready (rx_ready),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .tdo_i    (tdo_i),
        .asdo_i   (asdo_i),
        .tck_o    (tck_o),
        .tms_o    (tms_o),
        .nce_o    (nce_o),
        .ncs_o    (ncs_o),
        .tdi_o    (tdi_o),
        .drv_en_o (drv_en_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input int dly);
        logic t0, d0;
        bit   moved;
        moved = 1'b0;
        @(negedge clk);
        while (!rx_ready) @(negedge clk);
        t0 = tck_o;
        d0 = tdi_o;
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            if (tck_o !== t0 || tdi_o !== d0) moved = 1'b1;
        end
        if (dly > 0) chk(!moved, "R8 rx stall tck/tdi", int'({tck_o, tdi_o}), int'({t0, d0}));
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic recv(output logic [7:0] b, input int dly);
        logic [7:0] d0;
        logic       t0;
        bit         moved;
        moved = 1'b0;
        @(negedge clk);
        while (!tx_valid) @(negedge clk);
        d0 = tx_data;
        t0 = tck_o;
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            if (!tx_valid || tx_data !== d0 || tck_o !== t0) moved = 1'b1;
        end
        if (dly > 0) chk(!moved, "R8 tx stall hold", int'(tx_data), int'(d0));
        tx_ready = 1'b1;
        @(negedge clk);
        tx_ready = 1'b0;
        b = d0;
    endtask

    function automatic logic [5:0] pins_now();
        return {drv_en_o, tdi_o, ncs_o, nce_o, tms_o, tck_o};
    endfunction

    task automatic preset(input logic ncs);
        bb_mode = 1'b1;
        send({2'b00, 6'b100110 | {2'b00, ncs, 3'b000}}, 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_shift(input int n, input bit rd, input logic ncs, input int s, input int dly);
        logic [7:0] r, e, t;
        preset(ncs);
        mon_exp = {1'b1, ncs, 1'b1, 1'b1};
        glitch  = 1'b0;
        txseen  = 1'b0;
        seed    = s;
        bb_mode = 1'b0;
        bitidx  = 0;
        mon_on  = 1'b1;
        send({1'b1, rd, 6'(n)}, 0);
        for (int k = 0; k < n; k++) begin
            send(dbyte(k, s), dly);
            if (rd) begin
                recv(r, dly);
                for (int j = 0; j < 8; j++) e[j] = patbit(8 * k + j, ncs ? s : s + 3);
                chk(r === e, ncs ? "R7 R6 captured byte from TDO" : "R7 R6 captured byte from ASDO",
                    int'(r), int'(e));
            end
        end
        repeat (30) @(negedge clk);
        mon_on = 1'b0;
        for (int k = 0; k < n; k++) begin
            for (int j = 0; j < 8; j++) t[j] = tdi_log[8 * k + j];
            chk(t === dbyte(k, s), "R5 TDI bits LSB first", int'(t), int'(dbyte(k, s)));
        end
        chk(bitidx == 8 * n, "R5 TCK rising edges", bitidx, 8 * n);
        chk(tck_o === 1'b0, "R9 TCK low after transfer", int'(tck_o), 0);
        chk(!glitch, "R9 other pins held", int'(glitch), 0);
        if (!rd) chk(!txseen, "R7 no response without read bit", int'(txseen), 0);
        bb_mode = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R8 watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;

        // Host resync from an unknown start.
        tx_ready = 1'b1;
        for (int i = 0; i < 64; i++) send(8'h00, 0);
        tx_ready = 1'b0;
        repeat (4) @(negedge clk);
        chk(pins_now() === 6'h00 && tx_valid === 1'b0, "R10 state after 64 zero bytes",
            int'({tx_valid, pins_now()}), 0);

        // Bit-bang with read-back: every pin value under every input pair.
        for (int v = 0; v < 64; v++) begin
            for (int io = 0; io < 4; io++) begin
                tdo_f  = io[0];
                asdo_f = io[1];
                send(8'h40 | 8'(v), 0);
                @(negedge clk);
                chk(pins_now() === 6'(v), "R1 bit-bang pin map", int'(pins_now()), v);
                recv(r, (v % 3 == 0) ? 2 : 0);
                chk(r === {6'b0, asdo_f, tdo_f}, "R2 read-back byte", int'(r), int'({asdo_f, tdo_f}));
            end
        end

        // Bit-bang without read-back.
        for (int v = 0; v < 64; v++) begin
            txseen = 1'b0;
            send(8'(v), 0);
            @(negedge clk);
            chk(pins_now() === 6'(v), "R1 bit-bang pin map", int'(pins_now()), v);
            for (int i = 0; i < 4; i++) begin
                @(negedge clk);
                if (tx_valid) txseen = 1'b1;
            end
            chk(!txseen, "R3 no response", int'(txseen), 0);
        end

        // Zero-count shift: the next byte must be decoded as a command.
        send(8'h2A, 0);
        send(8'h80, 0);
        send(8'hC0, 0);
        tdo_f  = 1'b0;
        asdo_f = 1'b1;
        send(8'h55, 0);
        @(negedge clk);
        chk(pins_now() === 6'h15, "R4 zero count consumes nothing", int'(pins_now()), 'h15);
        recv(r, 0);
        chk(r === 8'h02, "R4 command after zero count", int'(r), 2);

        // Byte-shift sweep.
        for (int n = 1; n <= 5; n += 2) begin
            for (int m = 0; m < 4; m++) begin
                run_shift(n, m[0], m[1], n * 4 + m, (m == 3) ? 2 : 0);
            end
        end
        run_shift(2, 1'b1, 1'b1, 9, 3);

        // Resync from the middle of a 63-byte read transfer.
        preset(1'b1);
        seed    = 21;
        bb_mode = 1'b0;
        bitidx  = 0;
        send(8'hFF, 0);
        for (int k = 0; k < 3; k++) begin
            send(dbyte(k, 21), 0);
            recv(r, 0);
        end
        tx_ready = 1'b1;
        for (int i = 0; i < 64; i++) send(8'h00, 0);
        tx_ready = 1'b0;
        repeat (4) @(negedge clk);
        chk(pins_now() === 6'h00 && tx_valid === 1'b0, "R10 resync mid-transfer",
            int'({tx_valid, pins_now()}), 0);
        bb_mode = 1'b1;
        tdo_f   = 1'b1;
        asdo_f  = 1'b0;
        send(8'h40 | 8'h2D, 0);
        @(negedge clk);
        chk(pins_now() === 6'h2D, "R10 command after resync", int'(pins_now()), 'h2D);
        recv(r, 0);
        chk(r === 8'h01, "R10 read-back after resync", int'(r), 1);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule